// File: doc/BRIEF.md
# Register-File-Backed Victim Cache

This block is a victim cache that sits beside a first-level data cache and holds the lines that cache evicts. It keeps only a tag, a valid flag and a register index for each entry. The line data lives in a register of the shader register file that the running kernel has not claimed. A bitmap with one bit per register is loaded before each kernel launch and says which registers may be borrowed. An evicted line is written into a borrowed register through the register-file write port. A later lookup that hits reads that register back through the register-file read port.

Lookups are fully associative on the tag. A hit hands the line back and releases the entry, because the line returns to the first-level cache. When a new line arrives the block takes the lowest-numbered free register. If no register or slot is free, it reuses the register of the least recently inserted entry. If it holds nothing at all, it drops the line. A kernel-start pulse or a new bitmap empties the cache. Defaults follow a warp-wide design: 1024-bit lines, 1024 registers and 128 entries, so each entry carries a 10-bit index.

Top module: `rf_victim_cache`

## Requirements
- R1: After reset no entry is valid, every output strobe is low, and every register counts as allocated (bitmap all ones), so no insert can be stored until a bitmap is loaded.
- R2: A lookup sampled at a clock edge gets `rsp_valid` high in the next cycle, with `rsp_hit` high exactly when a valid entry holds the same tag.
- R3: On a hit, `rf_rd_en` rises in the same cycle as the response, and `rf_rd_idx` is the register stored with the entry. One cycle later `out_valid` is high and `out_line` carries the register-file read data. The register file answers one cycle after a read.
- R4: A hit invalidates its entry and returns the entry's register to the free pool. A repeated lookup of the same tag misses.
- R5: An insert that is kept drives `rf_wr_en` in the next cycle, with `rf_wr_idx` and `rf_wr_line` carrying the line. The index never names a register whose bitmap bit is 1, or one held by another valid entry.
- R6: When a slot and a free register both exist, the insert takes the lowest-indexed register with bitmap bit 0 that no valid entry holds.
- R7: When all slots are valid, the insert replaces the least recently inserted valid entry and writes into that entry's register.
- R8: When slots are empty but no register is free, the insert replaces the least recently inserted valid entry and reuses its register.
- R9: When no register is free and no entry is valid, the insert is dropped: no write occurs and a later lookup of that tag misses.
- R10: `kstart` invalidates every entry and frees every borrowed register. A lookup or insert in the same cycle is ignored: no response and no write.
- R11: `map_load` replaces the bitmap with `map_bits` (bit i for register i, 1 = allocated) and invalidates every entry. A lookup or insert in the same cycle is ignored.
- R12: When a lookup and an insert arrive in the same cycle, the lookup is served and the insert is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| kstart | input | 1 | Kernel start: empty the cache |
| map_load | input | 1 | Load the register bitmap and empty the cache |
| map_bits | input | NUM_REGS | Bitmap, bit i = register i, 1 = allocated |
| lk_valid | input | 1 | Lookup request |
| lk_tag | input | TAG_W | Lookup tag |
| rsp_valid | output | 1 | Lookup response strobe |
| rsp_hit | output | 1 | Lookup hit |
| ins_valid | input | 1 | Insert of an evicted line |
| ins_tag | input | TAG_W | Tag of the evicted line |
| ins_line | input | LINE_W | Data of the evicted line |
| rf_wr_en | output | 1 | Register-file write enable |
| rf_wr_idx | output | log2(NUM_REGS) | Register-file write index |
| rf_wr_line | output | LINE_W | Register-file write data |
| rf_rd_en | output | 1 | Register-file read enable |
| rf_rd_idx | output | log2(NUM_REGS) | Register-file read index |
| rf_rd_line | input | LINE_W | Register-file read data, one cycle after the read |
| out_valid | output | 1 | Hit line valid |
| out_line | output | LINE_W | Hit line data |

## Verification
The hardest state to reach from the ports is a cache with empty slots but no free register. The replacement then has to reuse a live register rather than take a new one. The same applies to the follow-on case where a hit has just returned a register and the next insert must pick it up again. The bench reaches both by loading bitmaps with only a handful of zero bits, and by interleaving hits and inserts so that the free pool runs dry. It checks every write index against a model of the pool, and every hit line against the data that model recorded. Random phases then mix sparse random bitmaps, kernel starts and inserts over a small tag space, so that full-cache and empty-pool cases recur often.

// File: rtl/vc_pkg.sv
// Package vc_pkg: types shared by the victim-cache modules.
// Assumes nothing beyond being compiled before its users.
package vc_pkg;
    // Placement outcome for an incoming evicted line
    typedef enum logic [1:0] {
        INS_DROP  = 2'd0,
        INS_NEW   = 2'd1,
        INS_REUSE = 2'd2
    } ins_kind_e;
endpackage

// File: rtl/vc_first_set.sv
// Module vc_first_set: finds the lowest set bit of a vector.
// Assumes W >= 1; idx is zero when nothing is set.
module vc_first_set #(
    parameter int W  = 8,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan from the top so the lowest set bit wins
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/vc_tag_store.sv
// Module vc_tag_store: tags, valid flags, register indices and insertion
// ages of all victim entries. Ages are exact ranks among valid entries
// (0 = newest), so the oldest entry has age == count-1.
// Assumes N is a power of two and that invalidate and insert never
// arrive in the same cycle.
module vc_tag_store #(
    parameter int N     = 128,
    parameter int TAG_W = 24,
    parameter int IDX_W = 10,
    localparam int SLOT_W = $clog2(N),
    localparam int CNT_W  = SLOT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_all,
    input  logic              inv_en,
    input  logic [SLOT_W-1:0] inv_slot,
    input  logic              ins_en,
    input  logic [SLOT_W-1:0] ins_slot,
    input  logic [TAG_W-1:0]  ins_tag,
    input  logic [IDX_W-1:0]  ins_reg,
    input  logic [TAG_W-1:0]  look_tag,
    output logic              hit,
    output logic [SLOT_W-1:0] hit_slot,
    output logic [IDX_W-1:0]  hit_reg,
    output logic              has_empty,
    output logic [SLOT_W-1:0] empty_slot,
    output logic              has_valid,
    output logic [SLOT_W-1:0] lru_slot,
    output logic [IDX_W-1:0]  lru_reg
);
    logic [N-1:0]      valid_q;
    logic [TAG_W-1:0]  tag_q   [N];
    logic [IDX_W-1:0]  regix_q [N];
    logic [SLOT_W-1:0] age_q   [N];
    logic [CNT_W-1:0]  count_q;

    logic [N-1:0] match_vec;
    logic [N-1:0] oldest_vec;
    logic         oldest_found;

    // Per-entry tag compare and oldest-rank detect
    always_comb begin
        for (int i = 0; i < N; i++) begin
            match_vec[i]  = valid_q[i] && (tag_q[i] == look_tag);
            oldest_vec[i] = valid_q[i] && ({1'b0, age_q[i]} == count_q - CNT_W'(1));
        end
    end

    vc_first_set #(.W(N)) u_hit_enc (
        .vec(match_vec), .found(hit), .idx(hit_slot)
    );

    vc_first_set #(.W(N)) u_empty_enc (
        .vec(~valid_q), .found(has_empty), .idx(empty_slot)
    );

    vc_first_set #(.W(N)) u_lru_enc (
        .vec(oldest_vec), .found(oldest_found), .idx(lru_slot)
    );

    // Register indices of the matching and the oldest entry
    always_comb begin
        hit_reg   = regix_q[hit_slot];
        lru_reg   = regix_q[lru_slot];
        has_valid = oldest_found;
    end

    // Entry state update: flush, invalidate with rank close-up, or insert
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            count_q <= '0;
            for (int i = 0; i < N; i++) begin
                tag_q[i]   <= '0;
                regix_q[i] <= '0;
                age_q[i]   <= '0;
            end
        end else if (clr_all) begin
            valid_q <= '0;
            count_q <= '0;
        end else if (inv_en) begin
            valid_q[inv_slot] <= 1'b0;
            count_q <= count_q - CNT_W'(1);
            for (int i = 0; i < N; i++) begin
                if (valid_q[i] && (age_q[i] > age_q[inv_slot])) begin
                    age_q[i] <= age_q[i] - SLOT_W'(1);
                end
            end
        end else if (ins_en) begin
            for (int i = 0; i < N; i++) begin
                if (valid_q[i] && (SLOT_W'(i) != ins_slot)) begin
                    age_q[i] <= age_q[i] + SLOT_W'(1);
                end
            end
            valid_q[ins_slot] <= 1'b1;
            tag_q[ins_slot]   <= ins_tag;
            regix_q[ins_slot] <= ins_reg;
            age_q[ins_slot]   <= '0;
            if (!valid_q[ins_slot]) begin
                count_q <= count_q + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/vc_reg_pool.sv
// Module vc_reg_pool: holds the kernel allocation bitmap and the set of
// registers currently lent to victim entries; reports the lowest free one.
// Assumes take and give never name the same register in one cycle.
module vc_reg_pool #(
    parameter int NR = 1024,
    localparam int IDX_W = $clog2(NR)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [NR-1:0]    load_map,
    input  logic             clr_busy,
    input  logic             take_en,
    input  logic [IDX_W-1:0] take_idx,
    input  logic             give_en,
    input  logic [IDX_W-1:0] give_idx,
    output logic             free_any,
    output logic [IDX_W-1:0] free_idx
);
    logic [NR-1:0] alloc_q;
    logic [NR-1:0] busy_q;

    vc_first_set #(.W(NR)) u_free_enc (
        .vec(~alloc_q & ~busy_q), .found(free_any), .idx(free_idx)
    );

    // Bitmap load and lend/return bookkeeping of borrowed registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alloc_q <= '1;
            busy_q  <= '0;
        end else if (load_en) begin
            alloc_q <= load_map;
            busy_q  <= '0;
        end else if (clr_busy) begin
            busy_q <= '0;
        end else begin
            if (take_en) busy_q[take_idx] <= 1'b1;
            if (give_en) busy_q[give_idx] <= 1'b0;
        end
    end
endmodule

// File: rtl/rf_victim_cache.sv
// Module rf_victim_cache: victim cache whose line storage is borrowed
// register-file registers. Decides hit/miss, placement and replacement,
// and drives the register-file read and write ports.
// Assumes the register file returns read data one cycle after rf_rd_en.
module rf_victim_cache #(
    parameter int NUM_ENTRIES = 128,
    parameter int NUM_REGS    = 1024,
    parameter int LINE_W      = 1024,
    parameter int TAG_W       = 24,
    localparam int SLOT_W = $clog2(NUM_ENTRIES),
    localparam int IDX_W  = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kstart,
    input  logic              map_load,
    input  logic [NUM_REGS-1:0] map_bits,
    input  logic              lk_valid,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              rsp_valid,
    output logic              rsp_hit,
    input  logic              ins_valid,
    input  logic [TAG_W-1:0]  ins_tag,
    input  logic [LINE_W-1:0] ins_line,
    output logic              rf_wr_en,
    output logic [IDX_W-1:0]  rf_wr_idx,
    output logic [LINE_W-1:0] rf_wr_line,
    output logic              rf_rd_en,
    output logic [IDX_W-1:0]  rf_rd_idx,
    input  logic [LINE_W-1:0] rf_rd_line,
    output logic              out_valid,
    output logic [LINE_W-1:0] out_line
);
    import vc_pkg::*;

    logic              flush, do_lk, do_ins, hit_now, ins_keep;
    logic              ts_hit, ts_has_empty, ts_has_valid;
    logic [SLOT_W-1:0] ts_hit_slot, ts_empty_slot, ts_lru_slot;
    logic [IDX_W-1:0]  ts_hit_reg, ts_lru_reg;
    logic              pl_free_any;
    logic [IDX_W-1:0]  pl_free_idx;
    ins_kind_e         ins_kind;
    logic [SLOT_W-1:0] ins_slot;
    logic [IDX_W-1:0]  ins_reg;

    // Request qualification: flushes win, lookups beat inserts
    always_comb begin
        flush    = kstart | map_load;
        do_lk    = lk_valid & ~flush;
        do_ins   = ins_valid & ~lk_valid & ~flush;
        hit_now  = do_lk & ts_hit;
        ins_keep = do_ins & (ins_kind != INS_DROP);
    end

    // Placement choice for an incoming line
    always_comb begin
        ins_kind = INS_DROP;
        ins_slot = ts_lru_slot;
        ins_reg  = ts_lru_reg;
        if (!ts_has_empty) begin
            ins_kind = INS_REUSE;
        end else if (pl_free_any) begin
            ins_kind = INS_NEW;
            ins_slot = ts_empty_slot;
            ins_reg  = pl_free_idx;
        end else if (ts_has_valid) begin
            ins_kind = INS_REUSE;
        end
    end

    vc_tag_store #(
        .N(NUM_ENTRIES), .TAG_W(TAG_W), .IDX_W(IDX_W)
    ) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_all    (flush),
        .inv_en     (hit_now),
        .inv_slot   (ts_hit_slot),
        .ins_en     (ins_keep),
        .ins_slot   (ins_slot),
        .ins_tag    (ins_tag),
        .ins_reg    (ins_reg),
        .look_tag   (lk_tag),
        .hit        (ts_hit),
        .hit_slot   (ts_hit_slot),
        .hit_reg    (ts_hit_reg),
        .has_empty  (ts_has_empty),
        .empty_slot (ts_empty_slot),
        .has_valid  (ts_has_valid),
        .lru_slot   (ts_lru_slot),
        .lru_reg    (ts_lru_reg)
    );

    vc_reg_pool #(.NR(NUM_REGS)) u_pool (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (map_load),
        .load_map (map_bits),
        .clr_busy (kstart),
        .take_en  (do_ins && (ins_kind == INS_NEW)),
        .take_idx (pl_free_idx),
        .give_en  (hit_now),
        .give_idx (ts_hit_reg),
        .free_any (pl_free_any),
        .free_idx (pl_free_idx)
    );

    // Registered response and register-file port drive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rf_rd_en   <= 1'b0;
            rf_rd_idx  <= '0;
            rf_wr_en   <= 1'b0;
            rf_wr_idx  <= '0;
            rf_wr_line <= '0;
            out_valid  <= 1'b0;
        end else begin
            rsp_valid <= do_lk;
            rsp_hit   <= hit_now;
            rf_rd_en  <= hit_now;
            if (hit_now) rf_rd_idx <= ts_hit_reg;
            rf_wr_en  <= ins_keep;
            if (ins_keep) begin
                rf_wr_idx  <= ins_reg;
                rf_wr_line <= ins_line;
            end
            out_valid <= rf_rd_en;
        end
    end

    // Hit data comes straight from the register-file read port
    always_comb out_line = rf_rd_line;
endmodule

// File: rtl/vc_checker.sv
// Module vc_checker: protocol and safety properties of rf_victim_cache,
// attached by bind. Keeps its own copy of the bitmap from the load port.
module vc_checker #(
    parameter int NUM_REGS = 1024,
    localparam int IDX_W = $clog2(NUM_REGS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                kstart,
    input logic                map_load,
    input logic [NUM_REGS-1:0] map_bits,
    input logic                lk_valid,
    input logic                ins_valid,
    input logic                rsp_valid,
    input logic                rsp_hit,
    input logic                rf_wr_en,
    input logic [IDX_W-1:0]    rf_wr_idx,
    input logic                rf_rd_en,
    input logic                out_valid
);
    logic [NUM_REGS-1:0] shadow_map;

    // Shadow of the kernel allocation bitmap
    always_ff @(posedge clk) begin
        if (!rst_n) shadow_map <= '1;
        else if (map_load) shadow_map <= map_bits;
    end

    AST_RSP_ON_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid && !kstart && !map_load |=> rsp_valid); // R2
    AST_RSP_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(lk_valid)); // R2
    AST_READ_ONLY_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        rf_rd_en |-> rsp_valid && rsp_hit); // R3
    AST_OUT_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_hit |=> out_valid); // R3
    AST_WR_UNALLOCATED: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> !shadow_map[rf_wr_idx]); // R5
    AST_KSTART_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(kstart) && lk_valid |=> !rsp_hit); // R10
    AST_MAPLOAD_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(map_load) && lk_valid |=> !rsp_hit); // R11
    AST_LOOKUP_BEATS_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid && ins_valid |=> !rf_wr_en); // R12
endmodule

bind rf_victim_cache vc_checker #(.NUM_REGS(NUM_REGS)) u_vc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .kstart    (kstart),
    .map_load  (map_load),
    .map_bits  (map_bits),
    .lk_valid  (lk_valid),
    .ins_valid (ins_valid),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rf_wr_en  (rf_wr_en),
    .rf_wr_idx (rf_wr_idx),
    .rf_rd_en  (rf_rd_en),
    .out_valid (out_valid)
);

// File: tb/test_rf_victim_cache.sv
`timescale 1ns/1ps
module test_rf_victim_cache;
    localparam int NE = 8;
    localparam int NR = 32;
    localparam int LW = 64;
    localparam int TW = 8;
    localparam int IW = $clog2(NR);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          kstart = 1'b0, map_load = 1'b0;
    logic [NR-1:0] map_bits = '0;
    logic          lk_valid = 1'b0, ins_valid = 1'b0;
    logic [TW-1:0] lk_tag = '0, ins_tag = '0;
    logic [LW-1:0] ins_line = '0;
    logic          rsp_valid, rsp_hit, rf_wr_en, rf_rd_en, out_valid;
    logic [IW-1:0] rf_wr_idx, rf_rd_idx;
    logic [LW-1:0] rf_wr_line, rf_rd_line, out_line;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    rf_victim_cache #(.NUM_ENTRIES(NE), .NUM_REGS(NR), .LINE_W(LW), .TAG_W(TW)) i_rf_victim_cache (
        .clk(clk), .rst_n(rst_n), .kstart(kstart), .map_load(map_load), .map_bits(map_bits),
        .lk_valid(lk_valid), .lk_tag(lk_tag), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .ins_valid(ins_valid), .ins_tag(ins_tag), .ins_line(ins_line),
        .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_line(rf_wr_line),
        .rf_rd_en(rf_rd_en), .rf_rd_idx(rf_rd_idx), .rf_rd_line(rf_rd_line),
        .out_valid(out_valid), .out_line(out_line)
    );

    // Register-file model with one-cycle read latency
    logic [LW-1:0] rf_mem [NR];
    always @(posedge clk) begin
        if (rf_wr_en) rf_mem[rf_wr_idx] <= rf_wr_line;
        if (rf_rd_en) rf_rd_line <= rf_mem[rf_rd_idx];
    end

    // Reference model
    bit            m_valid [NE];
    logic [TW-1:0] m_tag   [NE];
    logic [LW-1:0] m_data  [NE];
    int            m_reg   [NE];
    int            m_seq   [NE];
    logic [NR-1:0] m_map = '1;
    int            seq_ctr = 0;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int find_tag(logic [TW-1:0] t);
        for (int i = 0; i < NE; i++) if (m_valid[i] && m_tag[i] == t) return i;
        return -1;
    endfunction

    function automatic int oldest();
        int o = -1;
        for (int i = 0; i < NE; i++)
            if (m_valid[i] && (o < 0 || m_seq[i] < m_seq[o])) o = i;
        return o;
    endfunction

    function automatic int n_valid();
        int c = 0;
        for (int i = 0; i < NE; i++) if (m_valid[i]) c++;
        return c;
    endfunction

    function automatic int lowest_free();
        for (int r = 0; r < NR; r++) begin
            bit held = 0;
            if (m_map[r]) continue;
            for (int i = 0; i < NE; i++) if (m_valid[i] && m_reg[i] == r) held = 1;
            if (!held) return r;
        end
        return -1;
    endfunction

    function automatic int empty_slot();
        for (int i = 0; i < NE; i++) if (!m_valid[i]) return i;
        return -1;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < NE; i++) m_valid[i] = 0;
    endtask

    // Check a lookup response (and hit data) one cycle after the request
    task automatic check_lookup(logic [TW-1:0] t);
        int e = find_tag(t);
        chk("R2 rsp_valid", 64'(rsp_valid), 64'd1);
        chk("R2 rsp_hit", 64'(rsp_hit), 64'(e >= 0));
        if (e >= 0) begin
            chk("R3 rf_rd_en", 64'(rf_rd_en), 64'd1);
            chk("R3 rf_rd_idx", 64'(rf_rd_idx), 64'(m_reg[e]));
            m_valid[e] = 0;                               // R4: entry released
            @(negedge clk);
            chk("R3 out_valid", 64'(out_valid), 64'd1);
            chk("R3 out_line", 64'(out_line), 64'(m_data[e]));
        end
    endtask

    task automatic do_lookup(logic [TW-1:0] t);
        lk_valid = 1; lk_tag = t;
        @(negedge clk);
        lk_valid = 0;
        check_lookup(t);
    endtask

    task automatic do_insert(logic [TW-1:0] t, logic [LW-1:0] d);
        int slot = -1;
        int rg = -1;
        int f = lowest_free();
        int o = oldest();
        if (n_valid() == NE) begin slot = o; rg = m_reg[o]; end          // R7
        else if (f >= 0) begin slot = empty_slot(); rg = f; end           // R6
        else if (o >= 0) begin slot = o; rg = m_reg[o]; end               // R8
        ins_valid = 1; ins_tag = t; ins_line = d;
        @(negedge clk);
        ins_valid = 0;
        chk("R5/R9 rf_wr_en", 64'(rf_wr_en), 64'(slot >= 0));
        if (slot >= 0) begin
            chk("R6/R7/R8 rf_wr_idx", 64'(rf_wr_idx), 64'(rg));
            chk("R5 rf_wr_line", 64'(rf_wr_line), 64'(d));
            chk("R5 idx unallocated", 64'(m_map[rf_wr_idx]), 64'd0);
            m_valid[slot] = 1; m_tag[slot] = t; m_data[slot] = d;
            m_reg[slot] = rg; m_seq[slot] = seq_ctr++;
        end
    endtask

    task automatic do_kstart(bit with_req);
        kstart = 1; lk_valid = with_req; ins_valid = with_req;
        lk_tag = 8'h01; ins_tag = 8'h02;
        @(negedge clk);
        kstart = 0; lk_valid = 0; ins_valid = 0;
        chk("R10 no rsp", 64'(rsp_valid), 64'd0);
        chk("R10 no write", 64'(rf_wr_en), 64'd0);
        model_clear();
    endtask

    task automatic do_map(logic [NR-1:0] m);
        map_load = 1; map_bits = m;
        @(negedge clk);
        map_load = 0;
        chk("R11 no write", 64'(rf_wr_en), 64'd0);
        m_map = m;
        model_clear();
    endtask

    task automatic do_both(logic [TW-1:0] lt, logic [TW-1:0] it);
        lk_valid = 1; lk_tag = lt; ins_valid = 1; ins_tag = it; ins_line = '1;
        @(negedge clk);
        lk_valid = 0; ins_valid = 0;
        chk("R12 insert ignored", 64'(rf_wr_en), 64'd0);
        check_lookup(lt);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd7151);
        model_clear();
        repeat (3) @(negedge clk);
        chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R1 rf_wr_en", 64'(rf_wr_en), 64'd0);
        chk("R1 rf_rd_en", 64'(rf_rd_en), 64'd0);
        chk("R1 out_valid", 64'(out_valid), 64'd0);
        rst_n = 1;
        @(negedge clk);

        // R1/R9: default bitmap has nothing to lend
        do_insert(8'h11, 64'h1111);
        do_lookup(8'h11);

        // R6, R4, R8: four free registers (4..7)
        do_map(32'hFFFF_FF0F);
        do_insert(8'hA0, 64'hA0A0_0001);
        do_lookup(8'hA0);
        do_lookup(8'hA0);                       // R4: second lookup misses
        do_insert(8'hB0, 64'hB0B0_0002);        // R4/R6: register 4 again
        do_insert(8'hC0, 64'hC0C0_0003);
        do_insert(8'hD0, 64'hD0D0_0004);
        do_insert(8'hE0, 64'hE0E0_0005);
        do_insert(8'hF0, 64'hF0F0_0006);        // R8: reuses register of B0
        do_lookup(8'hB0);
        do_lookup(8'hF0);
        do_lookup(8'hD0);

        // R7: everything free, overfill the slots
        do_map(32'h0000_0000);
        for (int k = 0; k < NE + 1; k++) do_insert(TW'(8'h20 + k), {32'h5A5A_0000, 32'(k)});
        do_lookup(8'h20);
        do_lookup(8'h28);
        do_lookup(8'h23);

        // R10: kstart with requests in the same cycle, then empty
        do_insert(8'h40, 64'h4040);
        do_kstart(1'b1);
        do_lookup(8'h40);

        // R11: bitmap load empties
        do_insert(8'h41, 64'h4141);
        do_map(32'h0000_FFFF);
        do_lookup(8'h41);

        // R12: lookup and insert together
        do_insert(8'h42, 64'h4242);
        do_both(8'h42, 8'h43);
        do_lookup(8'h43);

        // R9: fully allocated bitmap drops inserts
        do_map('1);
        do_insert(8'h44, 64'h4444);
        do_lookup(8'h44);

        // Random phase
        do_map(32'h0000_0000);
        for (int n = 0; n < 1500; n++) begin
            int r = int'($urandom % 100);
            logic [TW-1:0] t = TW'($urandom % 24);
            if (r < 2) do_kstart(1'b0);
            else if (r < 5) do_map(($urandom % 2) ? NR'($urandom | $urandom) : NR'($urandom));
            else if (r < 50 && find_tag(t) < 0) do_insert(t, {$urandom, $urandom});
            else do_lookup(t);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule